// File: doc/BRIEF.md
# Double-Buffered SPI Controller

This block is a byte-wide SPI shift engine. It can act as bus master or as a selected slave, and software drives it through two registers. A select line picks the register: the status register or the data register. In master mode the block makes SCK from the system clock and shifts the byte out MSB first in SPI mode 0. In slave mode it follows an external SCK and chip select, which it synchronises to the system clock. When a byte finishes, a completion flag is raised. If both interrupt enables are high, that flag becomes an interrupt.

The block has two ways to write data. In single-buffered operation a data write loads the shifter directly, and a write made during a transfer is refused and flagged as a collision. In double-buffered operation every data write goes to a holding byte. That byte is moved into the shifter as soon as the shifter is free, or at the end of the current byte. This lets consecutive bytes run with no idle SCK time. A load-window bit shows software when refilling is timely. A slave-output disable bit lets several slaves share one MISO line.

Status layout, as read: bit 7 is the completion flag, bit 6 is the collision flag (single-buffered) or holding-full flag (double-buffered), bit 5 is the load window, bit 1 is the slave-output disable and bit 0 selects double buffering. Bits 4..2 read 0. Only bits 1 and 0 are writable.

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, SCK is low, the interrupt is low and the MISO output enable is low.
- R2: In master mode a byte takes 32 system clocks. SCK is low for 2 clocks and then high for 2 clocks per bit. MOSI carries the byte MSB first and changes only while SCK is low. MISO is sampled on each rising edge, and the received byte is read from the data register (register select = 1).
- R3: Status bit 7 is set when a byte completes. The interrupt output equals that bit ANDed with both interrupt enable inputs.
- R4: Status bit 7 is cleared only by a status read followed later by a data-register read or write. A data access with no status read before it leaves the bit set.
- R5: With status bit 0 = 0, a data write while a byte is shifting sets status bit 6 and does not change the byte being sent.
- R6: With status bit 0 = 0, status bit 6 is cleared by the same status-read-then-data-access sequence as bit 7.
- R7: With status bit 0 = 1, a data write stores the byte in the holding buffer and sets status bit 6. A second write before the buffer is moved replaces the pending byte, so only the last byte written is sent.
- R8: With status bit 0 = 1, status bit 6 is unaffected by the clear sequence. It drops only when the holding byte enters the shifter.
- R9: With status bit 0 = 1, if the holding buffer is full when a byte ends, the next byte's first SCK rise follows the previous rise by exactly 4 clocks.
- R10: Status bit 5 reads 1 while the first four bits of a byte are shifting. It reads 0 during the last four bits and while idle.
- R11: The MISO output enable is high only in slave mode, with chip select low and status bit 1 = 0. Status bit 1 is writable and reads back.
- R12: In slave mode the block samples MOSI on the rising edge of the synchronised SCK and shifts its preloaded byte out on MISO, MSB first. After 8 bits it raises status bit 7 and presents the received byte in the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 1 | 0 selects status, 1 selects data |
| reg_rd | input | 1 | Register read strobe (one clock) |
| reg_wr | input | 1 | Register write strobe (one clock) |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for the selected register |
| master | input | 1 | 1 = master role, 0 = slave role |
| irq_en | input | 1 | SPI interrupt enable |
| glb_en | input | 1 | Global serial interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Generated SCK (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| sck_i | input | 1 | External SCK (slave) |
| ss_n_i | input | 1 | Chip select, active low (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Output enable for the MISO pad |

## Verification
On every clock cycle, the assertions check:
- the shape of SCK;
- that MOSI is stable while SCK is high;
- that the completion and collision flags rise only for a legal cause;
- that the completion flag survives any cycle without a data access;
- that the holding-full flag drops only as a new byte starts;
- that back-to-back reloads keep the shifter busy;
- that the MISO enable is off when disabled.

Only the bench scenarios can show the rest. These are the serial byte values and their order against the scoreboard (including the overwritten holding byte), the two-step clear sequence with and without its first step, the load-window timing within a byte, the gapless SCK spacing at a byte boundary, and a full slave-mode exchange.

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic         reg_rd,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         master,
  input  logic         irq_en,
  input  logic         glb_en,
  output logic         irq,
  output logic         sck_o,
  output logic         mosi_o,
  input  logic         miso_i,
  input  logic         sck_i,
  input  logic         ss_n_i,
  input  logic         mosi_i,
  output logic         miso_o,
  output logic         miso_oe
);
  localparam int CW   = $clog2(W);
  localparam int HALF = W / 2;

  logic [W-1:0]  sr, rxd, txb;
  logic [CW-1:0] bitcnt;
  logic [1:0]    ph;
  logic          samp, busy, spif, wcol, full, armed, dis, enh;
  logic [2:0]    sck_sy, ss_sy;
  logic [1:0]    mosi_sy;

  wire sck_s = sck_sy[1];
  wire sck_q = sck_sy[2];
  wire ss_s  = ss_sy[1];

  wire st_rd  = reg_rd & ~reg_sel;
  wire st_wr  = reg_wr & ~reg_sel;
  wire dt_wr  = reg_wr & reg_sel;
  wire dt_acc = reg_sel & (reg_rd | reg_wr);

  wire m_rise = master & busy & (ph == 2'd1);
  wire m_fall = master & busy & (ph == 2'd3);
  wire s_sel  = ~master & ~ss_s;
  wire s_rise = s_sel & sck_s & ~sck_q;
  wire s_fall = s_sel & ~sck_s & sck_q & busy;
  wire rise   = m_rise | s_rise;
  wire fall   = m_fall | s_fall;
  wire last   = fall & (bitcnt == CW'(W - 1));

  wire nwr  = dt_wr & ~enh & ~busy;
  wire coll = dt_wr & ~enh & busy;
  wire ld   = enh & full & (~busy | last);
  wire lden = busy & (bitcnt < CW'(HALF));

  wire [7:0] status = {spif, enh ? full : wcol, lden, 3'b000, dis, enh};

  assign reg_rdata = reg_sel ? rxd : W'(status);
  assign irq       = spif & irq_en & glb_en;
  assign sck_o     = master & busy & ph[1];
  assign mosi_o    = sr[W-1];
  assign miso_o    = sr[W-1];
  assign miso_oe   = ~master & ~ss_s & ~dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      ss_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck_i};
      ss_sy   <= {ss_sy[1:0], ss_n_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      rxd    <= '0;
      bitcnt <= '0;
      ph     <= '0;
      samp   <= 1'b0;
      busy   <= 1'b0;
    end else begin
      if (master & busy) ph <= ph + 2'd1;
      if (rise) samp <= master ? miso_i : mosi_sy[1];
      if (s_rise & ~busy) busy <= 1'b1;
      if (fall) begin
        sr     <= {sr[W-2:0], samp};
        bitcnt <= bitcnt + CW'(1);
      end
      if (last) begin
        rxd  <= {sr[W-2:0], samp};
        busy <= 1'b0;
      end
      if (~master & ss_s) begin
        busy   <= 1'b0;
        bitcnt <= '0;
      end
      if (nwr) begin
        sr <= reg_wdata;
        if (master) begin
          busy   <= 1'b1;
          ph     <= '0;
          bitcnt <= '0;
        end
      end
      if (ld) begin
        sr     <= txb;
        bitcnt <= '0;
        if (master) begin
          busy <= 1'b1;
          ph   <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spif  <= 1'b0;
      wcol  <= 1'b0;
      full  <= 1'b0;
      armed <= 1'b0;
      dis   <= 1'b0;
      enh   <= 1'b0;
      txb   <= '0;
    end else begin
      if (st_rd) armed <= 1'b1;
      else if (dt_acc) armed <= 1'b0;
      if (dt_acc & armed) begin
        spif <= 1'b0;
        if (~enh) wcol <= 1'b0;
      end
      if (last) spif <= 1'b1;
      if (coll) wcol <= 1'b1;
      if (ld) full <= 1'b0;
      if (dt_wr & enh) begin
        txb  <= reg_wdata;
        full <= 1'b1;
      end
      if (st_wr) begin
        dis <= reg_wdata[1];
        enh <= reg_wdata[0];
      end
    end
  end
endmodule

// File: rtl/spi_dbuf_ctrl_sva.sv
module spi_dbuf_ctrl_sva #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master,
  input logic          reg_sel,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic          sck_o,
  input logic          mosi_o,
  input logic          miso_oe,
  input logic          busy,
  input logic          spif,
  input logic          wcol,
  input logic          full,
  input logic          enh,
  input logic          dis,
  input logic          last,
  input logic [CW-1:0] bitcnt
);
  a_r2_sck_shape: assert property (@(posedge clk) disable iff (!rst_n)
    master && $rose(sck_o) |=> sck_o ##1 !sck_o);

  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    master && sck_o |-> $stable(mosi_o));

  a_r3_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> $past(busy));

  a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    spif && !(reg_sel && (reg_rd || reg_wr)) |=> spif);

  a_r5_coll_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(reg_wr && reg_sel && busy && !enh));

  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) && master |-> busy && bitcnt == '0);

  a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    master && enh && full && last |=> busy);

  a_r11_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    dis || master |-> !miso_oe);
endmodule

bind spi_dbuf_ctrl spi_dbuf_ctrl_sva #(.CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .master(master), .reg_sel(reg_sel),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .sck_o(sck_o), .mosi_o(mosi_o),
  .miso_oe(miso_oe), .busy(busy), .spif(spif), .wcol(wcol), .full(full),
  .enh(enh), .dis(dis), .last(last), .bitcnt(bitcnt)
);

// File: tb/tb_spi_dbuf_ctrl.sv
`timescale 1ns/1ps
module tb_spi_dbuf_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic master = 1'b1, irq_en = 1'b1, glb_en = 1'b1, irq;
  logic sck_o, mosi_o, miso_i, miso_o, miso_oe;
  logic sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string sb_tag = "R2";
  logic [7:0] sl_byte = 8'hA5, sl_sh = 8'hA5, mbits = '0;
  int nb = 0;
  time last_rise = 0, boundary_gap = 0;

  always #5 clk = ~clk;

  spi_dbuf_ctrl #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .master(master), .irq_en(irq_en), .glb_en(glb_en), .irq(irq),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i),
    .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  assign miso_i = sl_sh[7];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge sck_o) begin
    if (nb == 0 && last_rise != 0) boundary_gap = $time - last_rise;
    last_rise = $time;
    mbits = {mbits[6:0], mosi_o};
    nb++;
    if (nb == 8) begin
      nb = 0;
      if (exp_q.size() == 0) chk({sb_tag, " unexpected byte"}, mbits, 32'hFFFF);
      else chk({sb_tag, " serial byte"}, mbits, exp_q.pop_front());
    end
  end

  always @(negedge sck_o) begin
    if (nb == 0) sl_sh = sl_byte;
    else sl_sh = {sl_sh[6:0], 1'b0};
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq(string tag);
    int n = 0;
    while (!irq && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(tag, irq, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, v);
    chk("R1 status", v, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 sck", sck_o, 0);
    chk("R1 miso_oe", miso_oe, 0);

    // R2 / R10 / R3 / R4: single-buffered master byte
    sb_tag = "R2";
    exp_q.push_back(8'h3C);
    wr(1, 8'h3C);
    repeat (5) @(negedge clk);
    rd(0, v);
    chk("R10 window open early", v[5], 1);
    repeat (10) @(negedge clk);
    rd(0, v);
    chk("R10 window closed late", v[5], 0);
    rd(1, v);
    wait_irq("R3 irq on completion");
    glb_en = 1'b0;
    #1 chk("R3 irq gated", irq, 0);
    glb_en = 1'b1;
    rd(1, v);
    chk("R2 received byte", v, 8'hA5);
    rd(0, v);
    chk("R4 flag kept without status read", v[7], 1);
    rd(1, v);
    rd(0, v);
    chk("R4 flag cleared by sequence", v[7], 0);
    chk("R4 irq low", irq, 0);
    rd(0, v);
    chk("R10 window idle", v[5], 0);

    // R5 / R6: collision in single-buffered mode
    sb_tag = "R5";
    exp_q.push_back(8'h5A);
    wr(1, 8'h5A);
    repeat (8) @(negedge clk);
    wr(1, 8'hFF);
    rd(0, v);
    chk("R5 collision set", v[6], 1);
    wait_irq("R5 completion");
    rd(0, v);
    chk("R6 collision held", v[7:6], 2'b11);
    rd(1, v);
    chk("R2 received byte again", v, 8'hA5);
    rd(0, v);
    chk("R6 flags cleared", v[7:6], 2'b00);

    // R7 / R8 / R9: double-buffered
    wr(0, 8'h01);
    rd(0, v);
    chk("R7 mode bit", v, 8'h01);
    last_rise = 0;
    boundary_gap = 0;
    sb_tag = "R7";
    exp_q.push_back(8'h11);
    exp_q.push_back(8'h33);
    wr(1, 8'h11);
    wr(1, 8'h22);
    rd(0, v);
    chk("R7 buffer full", v[6], 1);
    wr(1, 8'h33);
    rd(0, v);
    rd(1, v);
    rd(0, v);
    chk("R8 full survives clear sequence", v[6], 1);
    wait_irq("R8 first byte done");
    rd(0, v);
    chk("R8 full dropped at reload", v[7:6], 2'b10);
    rd(1, v);
    wait_irq("R9 second byte done");
    chk("R9 boundary gap ns", 32'(boundary_gap), 40);
    chk("R7 all bytes sent", exp_q.size(), 0);
    rd(0, v);
    rd(1, v);
    wr(0, 8'h00);

    // R11 / R12: slave
    master = 1'b0;
    @(negedge clk);
    chk("R11 oe off while deselected", miso_oe, 0);
    wr(1, 8'hC3);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 oe on when selected", miso_oe, 1);
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      mosi_i = 8'h96 >> i;
      repeat (8) @(negedge clk);
      got[i] = miso_o;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk("R12 slave sent byte", got, 8'hC3);
    chk("R12 slave completion irq", irq, 1);
    rd(0, v);
    rd(1, v);
    chk("R12 slave received byte", v, 8'h96);
    wr(0, 8'h02);
    repeat (4) @(negedge clk);
    chk("R11 oe off when disabled", miso_oe, 0);
    rd(0, v);
    chk("R11 disable bit reads back", v, 8'h02);
    ss_n_i = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule